// File: doc/BRIEF.md
# Multi-Mode Complementary PWM Generator

This block drives one or more complementary output pairs for a switching power stage. A master counter sets the switching period. Each pair turns that counter into its own local time base by subtracting a programmable phase offset. A single duty value and an alignment mode decide where the pulse sits inside the period: it can start the period, end the period, or sit centred in it. Each pair then splits its pulse into a high-side and a low-side output. A separately programmable dead time is inserted ahead of each side's rising edge.

Software-visible settings are written into shadow registers through a one-cycle write strobe with an address and data. The generator copies them into its working copies only on the last clock of a period, or when switching starts. A one-clock strobe marks the first clock of every period. A synchronous enable stops all outputs in the cycle it drops. When enable returns, switching restarts from the beginning of a fresh period.

Top module: `pwm_gen_top`

## Requirements
- R1: In alignment code 0 (trailing), the pulse of a pair is high for local times 0 to D-1, where D is the duty count in clocks.
- R2: In alignment code 1 (leading), the pulse is high for local times P-D to P-1, where P is the period in clocks. Code 3 behaves like code 0.
- R3: In alignment code 2 (centred), the pulse starts at local time floor((P-D)/2) and lasts D clocks.
- R4: The period is P = max(period register, 1) * STEP clocks. The strobe output is high for exactly one clock per period, in the same cycle as the output samples for master time 0.
- R5: The high side rises only after the pulse has been high for more than the rise dead time, and it falls together with the pulse. The low side is high only after the pulse has been low for more than the fall dead time, and it falls together with the pulse's rise.
- R6: A pulse (or a gap between pulses) no longer than the relevant dead time produces no pulse on that side.
- R7: The high and low outputs of one pair are never high in the same cycle.
- R8: The local time of a pair is (master time - phase) mod P. A phase value of P or more is treated as P-1.
- R9: A duty value above P is treated as P, so the pulse never ends. A duty of 0 produces no pulse.
- R10: Written values take effect at the first clock of the next period. A write in the middle of a period does not change that period.
- R11: While enable is low, and after reset, all outputs and the strobe are 0. They go to 0 in the same cycle that enable falls. After enable rises, the first cycle shows all outputs low, and the next cycle is master time 0 with the strobe high.
- R12: The write address is split into a page (upper bits) and a field (bits 1:0). On page 0, field 0 is the period, field 1 the duty and field 2 the alignment code. On page k+1, field 0 is the phase of pair k, field 1 its rise dead time and field 2 its fall dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Synchronous switching enable |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_addr_i | input | AW | Page and field of the write |
| wr_data_i | input | DW | Write data |
| pwm_hi_o | output | NUM_PAIRS | High-side output of each pair |
| pwm_lo_o | output | NUM_PAIRS | Low-side output of each pair |
| strobe_o | output | 1 | One-clock period start marker |

## Verification
The bench builds the block with two pairs, STEP of 4, a 4-bit period register and 3-bit dead times. Periods are therefore 4 or 8 clocks, and every alignment mode, dead-time boundary and phase wrap can be checked over whole periods within a few dozen cycles. A dead time of 7 exceeds the duties used, and a phase of 20 exceeds the 8-clock period, which brings the short-pulse suppression and phase clamping within reach. A duty of 12 against 8 clocks exercises the duty clamp. Period register values 0 and 1 both give the shortest period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ALIGN_TRAIL  = 2'd0,
        ALIGN_LEAD   = 2'd1,
        ALIGN_CENTER = 2'd2,
        ALIGN_SPARE  = 2'd3
    } align_e;

    localparam logic [1:0] FLD_0 = 2'd0;
    localparam logic [1:0] FLD_1 = 2'd1;
    localparam logic [1:0] FLD_2 = 2'd2;

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int PER_W     = 8,
    parameter int CNT_W     = 12,
    parameter int DT_W      = 6,
    parameter int AW        = 4,
    parameter int DW        = 12
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_en_i,
    input  logic [AW-1:0]                       wr_addr_i,
    input  logic [DW-1:0]                       wr_data_i,
    output logic [PER_W-1:0]                    sh_per_o,
    output logic [CNT_W-1:0]                    sh_duty_o,
    output align_e                              sh_mode_o,
    output logic [NUM_PAIRS-1:0][CNT_W-1:0]     sh_phase_o,
    output logic [NUM_PAIRS-1:0][DT_W-1:0]      sh_dtr_o,
    output logic [NUM_PAIRS-1:0][DT_W-1:0]      sh_dtf_o
);
    localparam int PG_W = AW - 2;

    typedef struct packed {
        logic [PER_W-1:0]                per;
        logic [CNT_W-1:0]                duty;
        align_e                          mode;
        logic [NUM_PAIRS-1:0][CNT_W-1:0] ph;
        logic [NUM_PAIRS-1:0][DT_W-1:0]  dtr;
        logic [NUM_PAIRS-1:0][DT_W-1:0]  dtf;
    } shadow_t;

    shadow_t s_d, s_q;
    logic [PG_W-1:0] page;
    logic [1:0]      field;

    assign page  = wr_addr_i[AW-1:2];
    assign field = wr_addr_i[1:0];

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            if (page == '0) begin
                case (field)
                    FLD_0:   s_d.per  = wr_data_i[PER_W-1:0];
                    FLD_1:   s_d.duty = wr_data_i[CNT_W-1:0];
                    FLD_2:   s_d.mode = align_e'(wr_data_i[1:0]);
                    default: ;
                endcase
            end
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (page == PG_W'(p + 1)) begin
                    case (field)
                        FLD_0:   s_d.ph[p]  = wr_data_i[CNT_W-1:0];
                        FLD_1:   s_d.dtr[p] = wr_data_i[DT_W-1:0];
                        FLD_2:   s_d.dtf[p] = wr_data_i[DT_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sh_per_o   = s_q.per;
    assign sh_duty_o  = s_q.duty;
    assign sh_mode_o  = s_q.mode;
    assign sh_phase_o = s_q.ph;
    assign sh_dtr_o   = s_q.dtr;
    assign sh_dtf_o   = s_q.dtf;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int PER_W   = 8,
    parameter int STEP_SH = 4,
    parameter int CNT_W   = PER_W + STEP_SH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [PER_W-1:0] sh_per_i,
    input  logic [CNT_W-1:0] sh_duty_i,
    input  align_e           sh_mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_clk_o,
    output logic [CNT_W-1:0] duty_o,
    output align_e           mode_o,
    output logic             active_o,
    output logic             load_o,
    output logic             strobe_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [CNT_W-1:0] duty;
        align_e           mode;
        logic             strobe;
    } tbase_t;

    tbase_t t_d, t_q;
    logic [PER_W-1:0] per_eff;
    logic [CNT_W-1:0] per_clk;
    logic [CNT_W-1:0] last;
    logic             active;
    logic             load;

    always_comb begin
        per_eff = (t_q.per == '0) ? PER_W'(1) : t_q.per;
        per_clk = CNT_W'(per_eff) << STEP_SH;
        last    = per_clk - 1'b1;
        active  = en_i && t_q.run;
        load    = en_i && (!t_q.run || (t_q.cnt == last));

        t_d        = t_q;
        t_d.strobe = active && (t_q.cnt == '0);
        if (!en_i) begin
            t_d.run = 1'b0;
            t_d.cnt = '0;
        end else if (!t_q.run) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end else begin
            t_d.cnt = (t_q.cnt == last) ? '0 : t_q.cnt + 1'b1;
        end
        if (load) begin
            t_d.per  = sh_per_i;
            t_d.duty = sh_duty_i;
            t_d.mode = sh_mode_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign cnt_o     = t_q.cnt;
    assign per_clk_o = per_clk;
    assign duty_o    = (t_q.duty > per_clk) ? per_clk : t_q.duty;
    assign mode_o    = t_q.mode;
    assign active_o  = active;
    assign load_o    = load;
    assign strobe_o  = t_q.strobe;

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DT_W  = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] per_clk_i,
    input  logic [CNT_W-1:0] duty_i,
    input  align_e           mode_i,
    input  logic [CNT_W-1:0] sh_phase_i,
    input  logic [DT_W-1:0]  sh_dtr_i,
    input  logic [DT_W-1:0]  sh_dtf_i,
    output logic             hi_o,
    output logic             lo_o
);
    localparam int RW = DT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] ph;
        logic [DT_W-1:0]  dtr;
        logic [DT_W-1:0]  dtf;
        logic [RW-1:0]    run_hi;
        logic [RW-1:0]    run_lo;
        logic             hi;
        logic             lo;
    } pair_t;

    pair_t p_d, p_q;
    logic [CNT_W-1:0] ph_eff;
    logic [CNT_W-1:0] tl;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] start;
    logic [CNT_W:0]   stop_x;
    logic             raw;
    logic [RW-1:0]    nh;
    logic [RW-1:0]    nl;

    always_comb begin
        ph_eff = (p_q.ph >= per_clk_i) ? per_clk_i - 1'b1 : p_q.ph;
        tl     = (cnt_i >= ph_eff) ? cnt_i - ph_eff : cnt_i + per_clk_i - ph_eff;
        span   = per_clk_i - duty_i;
        start  = span >> 1;
        stop_x = {1'b0, start} + {1'b0, duty_i};
        case (mode_i)
            ALIGN_LEAD:   raw = (tl >= span);
            ALIGN_CENTER: raw = (tl >= start) && ({1'b0, tl} < stop_x);
            default:      raw = (tl < duty_i);
        endcase

        nh = raw  ? ((p_q.run_hi == '1) ? p_q.run_hi : p_q.run_hi + 1'b1) : '0;
        nl = !raw ? ((p_q.run_lo == '1) ? p_q.run_lo : p_q.run_lo + 1'b1) : '0;

        p_d = p_q;
        if (!active_i) begin
            p_d.run_hi = '0;
            p_d.run_lo = '0;
            p_d.hi     = 1'b0;
            p_d.lo     = 1'b0;
        end else begin
            p_d.run_hi = nh;
            p_d.run_lo = nl;
            p_d.hi     = raw  && (nh > {1'b0, p_q.dtr});
            p_d.lo     = !raw && (nl > {1'b0, p_q.dtf});
        end
        if (load_i) begin
            p_d.ph  = sh_phase_i;
            p_d.dtr = sh_dtr_i;
            p_d.dtf = sh_dtf_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign hi_o = p_q.hi;
    assign lo_o = p_q.lo;

endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
    import pwm_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int PER_W     = 8,
    parameter int STEP      = 16,
    parameter int DT_W      = 6,
    parameter int STEP_SH   = $clog2(STEP),
    parameter int CNT_W     = PER_W + STEP_SH,
    parameter int AW        = $clog2(NUM_PAIRS + 1) + 2,
    parameter int DW        = CNT_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [DW-1:0]        wr_data_i,
    output logic [NUM_PAIRS-1:0] pwm_hi_o,
    output logic [NUM_PAIRS-1:0] pwm_lo_o,
    output logic                 strobe_o
);
    logic [PER_W-1:0]                sh_per;
    logic [CNT_W-1:0]                sh_duty;
    align_e                          sh_mode;
    logic [NUM_PAIRS-1:0][CNT_W-1:0] sh_phase;
    logic [NUM_PAIRS-1:0][DT_W-1:0]  sh_dtr;
    logic [NUM_PAIRS-1:0][DT_W-1:0]  sh_dtf;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_clk;
    logic [CNT_W-1:0] duty;
    align_e           mode;
    logic             active;
    logic             load;
    logic             strobe;
    logic [NUM_PAIRS-1:0] hi_vec;
    logic [NUM_PAIRS-1:0] lo_vec;

    pwm_shadow_regs #(
        .NUM_PAIRS(NUM_PAIRS), .PER_W(PER_W), .CNT_W(CNT_W),
        .DT_W(DT_W), .AW(AW), .DW(DW)
    ) u_shadow (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .sh_per_o(sh_per), .sh_duty_o(sh_duty), .sh_mode_o(sh_mode),
        .sh_phase_o(sh_phase), .sh_dtr_o(sh_dtr), .sh_dtf_o(sh_dtf)
    );

    pwm_timebase #(
        .PER_W(PER_W), .STEP_SH(STEP_SH), .CNT_W(CNT_W)
    ) u_tbase (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
        .sh_per_i(sh_per), .sh_duty_i(sh_duty), .sh_mode_i(sh_mode),
        .cnt_o(cnt), .per_clk_o(per_clk), .duty_o(duty), .mode_o(mode),
        .active_o(active), .load_o(load), .strobe_o(strobe)
    );

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        pwm_pair #(
            .CNT_W(CNT_W), .DT_W(DT_W)
        ) u_pair (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .active_i(active), .load_i(load),
            .cnt_i(cnt), .per_clk_i(per_clk), .duty_i(duty), .mode_i(mode),
            .sh_phase_i(sh_phase[k]), .sh_dtr_i(sh_dtr[k]), .sh_dtf_i(sh_dtf[k]),
            .hi_o(hi_vec[k]), .lo_o(lo_vec[k])
        );
    end

    assign pwm_hi_o = hi_vec & {NUM_PAIRS{en_i}};
    assign pwm_lo_o = lo_vec & {NUM_PAIRS{en_i}};
    assign strobe_o = strobe & en_i;

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
    parameter int NUM_PAIRS = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 en_i,
    input logic [NUM_PAIRS-1:0] pwm_hi_o,
    input logic [NUM_PAIRS-1:0] pwm_lo_o,
    input logic                 strobe_o
);
    // R7
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwm_hi_o & pwm_lo_o) == '0);

    // R11
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (pwm_hi_o == '0) && (pwm_lo_o == '0) && !strobe_o);

    // R4
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);

    // R11
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en_i) ##1 en_i ##1 en_i |-> strobe_o);

    // R11
    first_cycle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en_i) ##1 en_i |-> !strobe_o && (pwm_hi_o == '0) && (pwm_lo_o == '0));

endmodule

bind pwm_gen_top pwm_gen_chk #(.NUM_PAIRS(NUM_PAIRS)) u_pwm_gen_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o), .strobe_o(strobe_o)
);

// File: tb/tb_pwm_gen_top.sv
`timescale 1ns/1ps
module tb_pwm_gen_top;
    localparam int NP    = 2;
    localparam int PER_W = 4;
    localparam int STEP  = 4;
    localparam int DT_W  = 3;
    localparam int CNT_W = PER_W + 2;
    localparam int AW    = $clog2(NP + 1) + 2;
    localparam int DW    = CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NP-1:0] hi, lo;
    logic strobe;

    always #2 clk = ~clk;

    pwm_gen_top #(.NUM_PAIRS(NP), .PER_W(PER_W), .STEP(STEP), .DT_W(DT_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pwm_hi_o(hi), .pwm_lo_o(lo), .strobe_o(strobe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    int cper, cduty, cmode;
    int cph[NP];
    int cdr[NP];
    int cdf[NP];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // scoreboard monitor: one expected item per cycle, sampled at negedge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({strobe, hi, lo} == e, t, int'({strobe, hi, lo}), int'(e));
            chk((hi & lo) == '0, "R7", int'(hi & lo), 0);
        end
    end

    task automatic wr(input int page, input int field, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'((page << 2) | field);
        wr_data = DW'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic defaults();
        cper = 2; cduty = 3; cmode = 0;
        for (int p = 0; p < NP; p++) begin
            cph[p] = 0; cdr[p] = 0; cdf[p] = 0;
        end
    endtask

    function automatic bit mraw(input int c, input int pp, input int d, input int md, input int ph);
        int p2, t, dc, s;
        p2 = (ph >= pp) ? pp - 1 : ph;
        t  = (c - p2 + pp) % pp;
        dc = (d > pp) ? pp : d;
        case (md)
            1: return t >= pp - dc;
            2: begin s = (pp - dc) / 2; return (t >= s) && (t < s + dc); end
            default: return t < dc;
        endcase
    endfunction

    // driver: program, enable, push the expected stream, optionally rewrite duty
    task automatic play(input int cycles, input string tag, input int new_duty);
        int pp;
        int rh[NP];
        int rl[NP];
        wr(0, 0, cper); wr(0, 1, cduty); wr(0, 2, cmode);
        for (int p = 0; p < NP; p++) begin
            wr(p + 1, 0, cph[p]); wr(p + 1, 1, cdr[p]); wr(p + 1, 2, cdf[p]);
            rh[p] = 0; rl[p] = 0;
        end
        pp = ((cper == 0) ? 1 : cper) * STEP;
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        #1;
        exp_q.push_back(5'b0); tag_q.push_back("R11 restart");
        for (int k = 0; k < cycles; k++) begin
            int c, d;
            logic [NP-1:0] eh, el;
            c = k % pp;
            d = (new_duty >= 0 && k >= pp) ? new_duty : cduty;
            for (int p = 0; p < NP; p++) begin
                bit r;
                r = mraw(c, pp, d, cmode, cph[p]);
                rh[p] = r ? rh[p] + 1 : 0;
                rl[p] = r ? 0 : rl[p] + 1;
                eh[p] = r && (rh[p] > cdr[p]);
                el[p] = !r && (rl[p] > cdf[p]);
            end
            exp_q.push_back({(c == 0), eh, el});
            tag_q.push_back(tag);
        end
        if (new_duty >= 0) begin
            wr(0, 1, new_duty);
            cduty = new_duty;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        en = 1'b0;
        #1;
        chk({strobe, hi, lo} == 5'b0, "R11 disable", int'({strobe, hi, lo}), 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk({strobe, hi, lo} == 5'b0, "R11 reset", int'({strobe, hi, lo}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({strobe, hi, lo} == 5'b0, "R11 idle", int'({strobe, hi, lo}), 0);

        defaults(); cmode = 0; cduty = 3;
        play(24, "R1 R4 trailing", -1);

        defaults(); cmode = 1; cduty = 3; cdr[0] = 1; cdf[0] = 2;
        play(24, "R2 R5 leading dead", -1);
        defaults(); cmode = 3; cduty = 5; cdr[1] = 2; cdf[1] = 1;
        play(16, "R2 R5 spare code", -1);

        defaults(); cmode = 2; cduty = 4;
        play(16, "R3 centre even", -1);
        defaults(); cmode = 2; cduty = 3; cdr[0] = 1;
        play(16, "R3 centre odd", -1);

        defaults(); cmode = 0; cduty = 2; cdr[0] = 2; cdr[1] = 1; cdf[1] = 7;
        play(16, "R6 short pulse", -1);

        defaults(); cmode = 0; cduty = 3; cph[1] = 3;
        play(16, "R8 R12 phase", -1);
        defaults(); cmode = 2; cduty = 2; cph[0] = 20; cph[1] = 5;
        play(16, "R8 R12 phase clamp", -1);

        defaults(); cduty = 12;
        play(16, "R9 duty clamp", -1);
        defaults(); cduty = 0; cdf[0] = 3;
        play(16, "R9 zero duty", -1);

        defaults(); cper = 0; cmode = 2; cduty = 2;
        play(12, "R4 min period zero", -1);
        defaults(); cper = 1; cmode = 1; cduty = 1;
        play(12, "R4 min period one", -1);

        defaults(); cmode = 0; cduty = 2;
        play(24, "R10 shadow update", 5);

        defaults(); cmode = 0; cduty = 4;
        play(13, "R11 mid-period stop", -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule